// File: doc/BRIEF.md
# Exception Entry Sequencer with Delay-Slot Check

This block runs the hardware entry sequence for two kinds of exception: a software trap, and an illegal instruction found sitting in the slot after a delayed branch. It watches a decoded instruction class each time the decoder presents one. It also takes a delay-slot marker, an FPU standby flag, a trap vector number and the candidate saved-PC values. From these it decides whether an exception starts and which cause wins.

Once a sequence starts, the block uses one memory port with a valid/ready handshake. It first fetches the handler address from the vector table. It then pushes the status word and the saved PC onto a downward-growing stack. Finally it issues a one-cycle redirect carrying the handler address, the new stack pointer and the status word. The redirect is a plain jump: nothing from the old stream runs in a delay slot after it. A busy output tells the pipeline to hold off further requests until the redirect has gone out.

Top module: `exc_entry_seq`

## Requirements
- R1: A trap accepted with vector number n reads the handler address from byte address vbr + 4*n. The value of vbr is sampled when the request is accepted.
- R2: Every sequence makes exactly three memory accesses in this order: a read of the vector entry, a write of the status word to SP-4, and a write of the saved PC to SP-8. SP is the stack pointer sampled at acceptance.
- R3: For a trap, the saved PC written to the stack is the nextPc input, which is the address of the instruction after the trap.
- R4: For a slot-illegal exception, the saved PC is the branchTarget input, and the vector read uses the fixed vector number SLOT_VEC (default 6, address vbr + 24).
- R5: With inDelaySlot high, these class codes raise slot-illegal: 1 (undefined), 2 (PC-writing), 3 (32-bit), 4 (register bank restore), 5 (signed divide), 6 (unsigned divide) and 8 (trap). Class 0 (plain) raises nothing.
- R6: Class 7 (floating-point or FPU-related) in a delay slot raises slot-illegal only while fpuStandby is 1. With fpuStandby at 0 it raises nothing.
- R7: While memValid is high and memReady is low, memValid stays high and memAddr holds its value.
- R8: busy is high from the cycle after acceptance until the cycle after the redirect. Requests presented while busy are ignored and cause no further memory access or redirect.
- R9: The redirect is a single-cycle pulse. During that pulse, newPc equals the word read from the vector table, newSp equals SP-8, and newSr equals the sampled status word.
- R10: If trap (class 8) and slot-illegal conditions hold at once, the slot-illegal cause wins. Its vector and saved PC are used.
- R11: A request outside a delay slot with any class other than 8 starts nothing: no memory access, no busy and no redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A decoded instruction is presented this cycle |
| insnClass | input | 4 | Decoded instruction class code |
| inDelaySlot | input | 1 | Instruction sits in a delayed-branch slot |
| fpuStandby | input | 1 | FPU is in module standby |
| trapVector | input | 8 | Vector number carried by a trap |
| nextPc | input | 32 | Address of the instruction after the current one |
| branchTarget | input | 32 | Jump target of the preceding delayed branch |
| curSr | input | 32 | Current status word |
| curSp | input | 32 | Current stack pointer |
| vbr | input | 32 | Vector table base address |
| busy | output | 1 | Sequence in progress |
| memValid | output | 1 | Memory request valid |
| memWrite | output | 1 | Request is a write |
| memAddr | output | 32 | Request byte address |
| memWdata | output | 32 | Write data |
| memReady | input | 1 | Memory completes the request this cycle |
| memRdata | input | 32 | Read data, valid with memReady |
| redirect | output | 1 | One-cycle jump strobe |
| newPc | output | 32 | Handler address |
| newSp | output | 32 | Stack pointer after the pushes |
| newSr | output | 32 | Status word to restore into SR |

## Verification
Every delay-slot class code is tried both inside and outside a slot. Class 7 is tried with standby on and off, which separates the FPU rule from the fixed illegal list. Traps are run at vector 0, at vector 255 and at random vectors with random stack, base and PC values, so address arithmetic and the choice of saved PC (next address versus branch target) are told apart per cause. The memory model inserts random wait states to expose handshake slips. A trap in a slot and requests held high during a running sequence probe priority and busy gating.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [3:0] {
    CLS_PLAIN   = 4'd0,
    CLS_UNDEF   = 4'd1,
    CLS_PCWRITE = 4'd2,
    CLS_WIDE    = 4'd3,
    CLS_BANKRST = 4'd4,
    CLS_SDIV    = 4'd5,
    CLS_UDIV    = 4'd6,
    CLS_FPU     = 4'd7,
    CLS_TRAP    = 4'd8
  } insnClassT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VREAD,
    ST_PUSHSR,
    ST_PUSHPC,
    ST_JUMP
  } seqStateT;

  typedef struct packed {
    logic capture;
    logic selSlot;
    logic addrVec;
    logic dataPc;
    logic loadHandler;
    logic decSp;
  } dpCtrlT;

endpackage

// File: rtl/exc_cause_decode.sv
module exc_cause_decode
  import exc_entry_pkg::*;
(
  input  logic [3:0] insnClass,
  input  logic       inDelaySlot,
  input  logic       fpuStandby,
  output logic       slotIllegal,
  output logic       trapReq
);

  logic fixedIllegal;
  logic fpuIllegal;

  always_comb begin
    case (insnClass)
      CLS_UNDEF, CLS_PCWRITE, CLS_WIDE, CLS_BANKRST,
      CLS_SDIV, CLS_UDIV, CLS_TRAP: fixedIllegal = 1'b1;
      default:                      fixedIllegal = 1'b0;
    endcase
  end

  assign fpuIllegal  = (insnClass == CLS_FPU) && fpuStandby;
  assign slotIllegal = inDelaySlot && (fixedIllegal || fpuIllegal);
  assign trapReq     = (insnClass == CLS_TRAP) && !slotIllegal;

endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_entry_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   slotIllegal,
  input  logic   trapReq,
  input  logic   memReady,
  output logic   busy,
  output logic   memValid,
  output logic   memWrite,
  output logic   redirect,
  output dpCtrlT ctrl
);

  seqStateT stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD   = stateQ;
    ctrl     = '0;
    memValid = 1'b0;
    memWrite = 1'b0;
    redirect = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (reqValid && (slotIllegal || trapReq)) begin
          ctrl.capture = 1'b1;
          ctrl.selSlot = slotIllegal;
          stateD       = ST_VREAD;
        end
      end
      ST_VREAD: begin
        memValid     = 1'b1;
        ctrl.addrVec = 1'b1;
        if (memReady) begin
          ctrl.loadHandler = 1'b1;
          stateD           = ST_PUSHSR;
        end
      end
      ST_PUSHSR: begin
        memValid = 1'b1;
        memWrite = 1'b1;
        if (memReady) begin
          ctrl.decSp = 1'b1;
          stateD     = ST_PUSHPC;
        end
      end
      ST_PUSHPC: begin
        memValid    = 1'b1;
        memWrite    = 1'b1;
        ctrl.dataPc = 1'b1;
        if (memReady) begin
          ctrl.decSp = 1'b1;
          stateD     = ST_JUMP;
        end
      end
      ST_JUMP: begin
        redirect = 1'b1;
        stateD   = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/exc_seq_datapath.sv
module exc_seq_datapath
  import exc_entry_pkg::*;
#(
  parameter int DW       = 32,
  parameter int VW       = 8,
  parameter int SLOT_VEC = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtrlT        ctrl,
  input  logic [VW-1:0] trapVector,
  input  logic [DW-1:0] nextPc,
  input  logic [DW-1:0] branchTarget,
  input  logic [DW-1:0] curSr,
  input  logic [DW-1:0] curSp,
  input  logic [DW-1:0] vbr,
  input  logic [DW-1:0] memRdata,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic [DW-1:0] newPc,
  output logic [DW-1:0] newSp,
  output logic [DW-1:0] newSr
);

  localparam int            PADW     = DW - VW - 2;
  localparam logic [DW-1:0] WORD     = DW'(4);
  localparam logic [VW-1:0] SLOT_NUM = VW'(SLOT_VEC);

  logic [DW-1:0] vbrQ, spQ, srQ, pcQ, handlerQ;
  logic [VW-1:0] vecQ;
  logic [DW-1:0] vecOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vbrQ     <= '0;
      spQ      <= '0;
      srQ      <= '0;
      pcQ      <= '0;
      handlerQ <= '0;
      vecQ     <= '0;
    end else begin
      if (ctrl.capture) begin
        vbrQ <= vbr;
        spQ  <= curSp;
        srQ  <= curSr;
        vecQ <= ctrl.selSlot ? SLOT_NUM : trapVector;
        pcQ  <= ctrl.selSlot ? branchTarget : nextPc;
      end
      if (ctrl.loadHandler) handlerQ <= memRdata;
      if (ctrl.decSp)       spQ      <= spQ - WORD;
    end
  end

  assign vecOffset = {{PADW{1'b0}}, vecQ, 2'b00};
  assign memAddr   = ctrl.addrVec ? (vbrQ + vecOffset) : (spQ - WORD);
  assign memWdata  = ctrl.dataPc ? pcQ : srQ;
  assign newPc     = handlerQ;
  assign newSp     = spQ;
  assign newSr     = srQ;

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int DW       = 32,
  parameter int VW       = 8,
  parameter int SLOT_VEC = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [3:0]    insnClass,
  input  logic          inDelaySlot,
  input  logic          fpuStandby,
  input  logic [VW-1:0] trapVector,
  input  logic [DW-1:0] nextPc,
  input  logic [DW-1:0] branchTarget,
  input  logic [DW-1:0] curSr,
  input  logic [DW-1:0] curSp,
  input  logic [DW-1:0] vbr,
  output logic          busy,
  output logic          memValid,
  output logic          memWrite,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memReady,
  input  logic [DW-1:0] memRdata,
  output logic          redirect,
  output logic [DW-1:0] newPc,
  output logic [DW-1:0] newSp,
  output logic [DW-1:0] newSr
);

  logic   slotIllegal;
  logic   trapReq;
  dpCtrlT ctrl;

  exc_cause_decode u_decode (
    .insnClass   (insnClass),
    .inDelaySlot (inDelaySlot),
    .fpuStandby  (fpuStandby),
    .slotIllegal (slotIllegal),
    .trapReq     (trapReq)
  );

  exc_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .slotIllegal (slotIllegal),
    .trapReq     (trapReq),
    .memReady    (memReady),
    .busy        (busy),
    .memValid    (memValid),
    .memWrite    (memWrite),
    .redirect    (redirect),
    .ctrl        (ctrl)
  );

  exc_seq_datapath #(
    .DW       (DW),
    .VW       (VW),
    .SLOT_VEC (SLOT_VEC)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .trapVector   (trapVector),
    .nextPc       (nextPc),
    .branchTarget (branchTarget),
    .curSr        (curSr),
    .curSp        (curSp),
    .vbr          (vbr),
    .memRdata     (memRdata),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .newPc        (newPc),
    .newSp        (newSp),
    .newSr        (newSr)
  );

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          busy,
  input logic          memValid,
  input logic          memWrite,
  input logic          memReady,
  input logic [DW-1:0] memAddr,
  input logic          redirect
);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memWrite)));

  assert_first_is_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (memValid && !memWrite));

  assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && !memWrite) |=> (memValid && memWrite));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (!redirect && !busy));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!memValid && !redirect));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busy),
  .memValid (memValid),
  .memWrite (memWrite),
  .memReady (memReady),
  .memAddr  (memAddr),
  .redirect (redirect)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [3:0]  insnClass = 4'd0;
  logic        inDelaySlot = 1'b0;
  logic        fpuStandby = 1'b0;
  logic [7:0]  trapVector = 8'd0;
  logic [31:0] nextPc = '0, branchTarget = '0, curSr = '0, curSp = '0, vbr = '0;
  logic        busy, memValid, memWrite, redirect;
  logic [31:0] memAddr, memWdata, newPc, newSp, newSr;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .insnClass(insnClass),
    .inDelaySlot(inDelaySlot), .fpuStandby(fpuStandby), .trapVector(trapVector),
    .nextPc(nextPc), .branchTarget(branchTarget), .curSr(curSr), .curSp(curSp),
    .vbr(vbr), .busy(busy), .memValid(memValid), .memWrite(memWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memReady(memReady),
    .memRdata(memRdata), .redirect(redirect), .newPc(newPc), .newSp(newSp),
    .newSr(newSr)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] tableWord(input logic [31:0] a);
    return (a * 32'd3) ^ 32'h1357_9BDF;
  endfunction

  function automatic bit slotExpected(input int cls, input bit slot, input bit fpu);
    if (!slot) return 1'b0;
    if (cls >= 1 && cls <= 6) return 1'b1;
    if (cls == 8) return 1'b1;
    if (cls == 7) return fpu;
    return 1'b0;
  endfunction

  // memory model and log
  logic [31:0] accAddr [0:7];
  logic [31:0] accData [0:7];
  bit          accWr   [0:7];
  int          nAcc = 0;
  int          redCount = 0;
  logic [31:0] redPc, redSp, redSr;
  bit          pending = 1'b0;
  int          waitLeft = 0;
  bit          stallSeen = 1'b0;
  logic [31:0] stallAddr = '0;

  always @(negedge clk) begin
    if (redirect) begin
      redCount++;
      redPc = newPc;
      redSp = newSp;
      redSr = newSr;
    end
    if (stallSeen)
      check(memValid && memAddr == stallAddr, "R7", "address held during stall",
            memAddr, stallAddr);
    stallSeen = 1'b0;
    if (!memValid) begin
      memReady = 1'b0;
      pending  = 1'b0;
    end else begin
      if (!pending) begin
        pending  = 1'b1;
        waitLeft = int'($urandom % 3);
      end
      if (waitLeft == 0) begin
        memReady = 1'b1;
        memRdata = tableWord(memAddr);
        if (nAcc < 8) begin
          accAddr[nAcc] = memAddr;
          accData[nAcc] = memWdata;
          accWr[nAcc]   = memWrite;
        end
        nAcc++;
        pending = 1'b0;
      end else begin
        memReady  = 1'b0;
        waitLeft--;
        stallSeen = 1'b1;
        stallAddr = memAddr;
      end
    end
  end

  task automatic runCase(input int cls, input bit slot, input bit fpu,
                         input logic [7:0] vec, input bit holdReq, input string tag);
    logic [31:0] sp, sr, nxt, tgt, base, expPc, vecAddr;
    bit expSlot, expTrap, expAny, done;
    sp   = 32'h2000_0000 + (($urandom % 4096) << 2);
    sr   = $urandom;
    nxt  = $urandom & ~32'h1;
    tgt  = $urandom & ~32'h1;
    base = 32'h0800_0000 + (($urandom % 256) << 10);
    expSlot = slotExpected(cls, slot, fpu);
    expTrap = !expSlot && cls == 8;
    expAny  = expSlot || expTrap;
    expPc   = expSlot ? tgt : nxt;
    vecAddr = base + (expSlot ? 32'd24 : {22'd0, vec, 2'b00});
    nAcc = 0;
    redCount = 0;
    @(negedge clk);
    reqValid = 1'b1; insnClass = 4'(cls); inDelaySlot = slot; fpuStandby = fpu;
    trapVector = vec; nextPc = nxt; branchTarget = tgt; curSr = sr; curSp = sp;
    vbr = base;
    @(negedge clk);
    reqValid = holdReq;
    if (holdReq) begin
      trapVector = ~vec; curSp = sp + 32'h100; inDelaySlot = 1'b0;
      insnClass = 4'd8;
    end
    check(busy == expAny, tag, "busy after request", 32'(busy), 32'(expAny));
    if (expAny) begin
      done = 1'b0;
      for (int i = 0; i < 60 && !done; i++) begin
        if (redirect) done = 1'b1;
        else @(negedge clk);
      end
      reqValid = 1'b0;
      check(done, "R9", "redirect seen", 32'(done), 32'd1);
    end
    reqValid = 1'b0;
    repeat (8) @(negedge clk);
    check(busy == 1'b0, "R8", "idle after sequence", 32'(busy), 32'd0);
    if (!expAny) begin
      check(nAcc == 0, tag, "no memory access", 32'(nAcc), 32'd0);
      check(redCount == 0, tag, "no redirect", 32'(redCount), 32'd0);
    end else begin
      check(nAcc == 3, holdReq ? "R8" : "R2", "access count", 32'(nAcc), 32'd3);
      check(redCount == 1, holdReq ? "R8" : "R9", "redirect count", 32'(redCount), 32'd1);
      if (nAcc >= 3) begin
        check(!accWr[0] && accAddr[0] == vecAddr, expSlot ? "R4" : "R1",
              "vector read address", accAddr[0], vecAddr);
        check(accWr[1] && accAddr[1] == sp - 4 && accData[1] == sr, "R2",
              "status push", accData[1], sr);
        check(accWr[2] && accAddr[2] == sp - 8, "R2", "pc push address",
              accAddr[2], sp - 8);
        check(accData[2] == expPc, expSlot ? (cls == 8 ? "R10" : "R4") : "R3",
              "saved pc", accData[2], expPc);
      end
      check(redPc == tableWord(vecAddr), "R9", "handler pc", redPc, tableWord(vecAddr));
      check(redSp == sp - 8, "R9", "new sp", redSp, sp - 8);
      check(redSr == sr, "R9", "new sr", redSr, sr);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(busy == 0 && memValid == 0 && redirect == 0, "R8", "reset state",
          {29'd0, busy, memValid, redirect}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed traps at vector extremes
    runCase(8, 0, 0, 8'd0, 0, "R1");
    runCase(8, 0, 1, 8'd255, 0, "R3");
    // every delay-slot class (R5), FPU rule (R6)
    for (int c = 0; c <= 6; c++) runCase(c, 1, 0, 8'd17, 0, "R5");
    runCase(7, 1, 1, 8'd3, 0, "R6");
    runCase(7, 1, 0, 8'd3, 0, "R6");
    // trap inside slot: priority R10
    runCase(8, 1, 0, 8'd99, 0, "R10");
    // non-trap outside slot: R11
    for (int c = 0; c <= 7; c++) runCase(c, 0, 1, 8'd5, 0, "R11");
    // requests held during busy: R8
    runCase(8, 0, 0, 8'd40, 1, "R8");
    runCase(2, 1, 0, 8'd41, 1, "R8");
    // random mix
    for (int k = 0; k < 60; k++)
      runCase(int'($urandom % 9), 1'($urandom), 1'($urandom), 8'($urandom),
              1'($urandom % 4 == 0), "R5");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule